// File: doc/BRIEF.md
# Status Register and Branch Decision Unit

This block keeps the four processor status flags (sign, zero, carry, overflow) and decides whether a jump request is taken. The flags change in three ways. The stack pop path can load all four at once. A single-bit command can set or clear one chosen flag. The ALU can write new values into the flags picked by a per-flag write mask. When several of these arrive in the same cycle, a fixed priority decides which one applies.

For control flow, the block compares one selected flag against a required polarity, or it accepts an unconditional request. The jump destination never comes from an instruction operand. It is always the 16-bit value formed by concatenating the separately loaded high and low jump bytes. The block also presents the current flags as a byte ready for pushing onto the stack. The program counter, memory and stack pointer are outside this block.

Top module: `status_branch_unit`

## Requirements
- R1: While reset is asserted, and after the synchronised release of reset, all four flags read 0 until the first update.
- R2: When `pop_load` is high, on the next clock edge the flags take `pop_flags`. Bit 3 is S, bit 2 is Z, bit 1 is C and bit 0 is V. This load overrides any bit command and any ALU update in the same cycle.
- R3: When `bit_cmd_en` is high and `bit_sel` has exactly one bit set (bit 3 S, bit 2 Z, bit 1 C, bit 0 V), and there is no pop, the selected flag becomes `bit_cmd_set` on the next edge and the other three flags keep their values. An ALU update in the same cycle is dropped.
- R4: When `bit_cmd_en` is high and `bit_sel` has zero bits or more than one bit set, the command changes no flag and `sel_err` is high in that same cycle. Any ALU update or pop in that cycle still applies as usual.
- R5: When there is no pop and no bit command, each flag whose bit in `alu_we` is 1 takes the matching bit of `alu_flags`, and each flag whose mask bit is 0 keeps its value. Bit positions are the same as in R2.
- R6: With no pop, no bit command and `alu_we` equal to 0, all flags hold their values.
- R7: With `br_req` high and `br_uncond` low, `taken` is high exactly when the selected flag equals `br_cond[0]`. `br_cond[2:1]` selects the flag: 0 selects V, 1 selects C, 2 selects Z and 3 selects S.
- R8: With `br_req` and `br_uncond` both high, `taken` is high whatever the flags and `br_cond` are.
- R9: With `br_req` low, `taken` is low.
- R10: `jump_target` always equals `{jr_hi, jr_lo}`, with `jr_hi` in the upper byte.
- R11: `push_byte` always equals the current flags in bits 3:0 (in the bit order of R2), with bits 7:4 equal to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| alu_flags | input | 4 | New flag values from the ALU |
| alu_we | input | 4 | Per-flag write mask for the ALU values |
| bit_cmd_en | input | 1 | Single-flag set/clear command valid |
| bit_cmd_set | input | 1 | Value written by the command: 1 sets the flag, 0 clears it |
| bit_sel | input | 4 | One-hot selection of the flag the command changes |
| pop_load | input | 1 | Parallel load of all flags from the stack pop path |
| pop_flags | input | 4 | Flag values popped from the stack |
| br_req | input | 1 | Jump request |
| br_uncond | input | 1 | The jump ignores the flags |
| br_cond | input | 3 | Condition code: flag select in bits 2:1, required polarity in bit 0 |
| jr_hi | input | 8 | High byte of the jump register |
| jr_lo | input | 8 | Low byte of the jump register |
| flags | output | 4 | Current flags {S, Z, C, V} |
| taken | output | 1 | The jump request is taken |
| jump_target | output | 16 | Jump destination |
| push_byte | output | 8 | Flag byte for a stack push |
| sel_err | output | 1 | A bit command had an invalid selection |

## Verification
The flag properties take for granted that every control input is 0 or 1 on each sampled edge. They also assume that the write mask, selection and data are meaningful only when their enable is high, so that the priority among pop, bit command and ALU update is what decides the outcome. The stimulus drives every input to a known value on each falling edge. Random cycles deliberately mix simultaneous pops, bit commands with one-hot, empty and multi-bit selections, and ALU masks, so each priority case and the invalid-selection case occur together with the others. Branch requests sweep all eight condition codes and the unconditional case against flag values produced by the same sequence.

// File: rtl/sbu_pkg.sv
package sbu_pkg;
  localparam int unsigned NFLAG  = 4;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned SEL_W  = CODE_W - 1;

  typedef enum logic [SEL_W-1:0] {
    FLG_V = 2'd0,
    FLG_C = 2'd1,
    FLG_Z = 2'd2,
    FLG_S = 2'd3
  } flag_idx_e;
endpackage

// File: rtl/sbu_rst_sync.sv
module sbu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/sbu_flag_store.sv
module sbu_flag_store
  import sbu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pop_load,
  input  logic [NFLAG-1:0] pop_flags,
  input  logic             cmd_en,
  input  logic             cmd_set,
  input  logic [NFLAG-1:0] cmd_sel,
  input  logic [NFLAG-1:0] alu_we,
  input  logic [NFLAG-1:0] alu_val,
  output logic [NFLAG-1:0] flags,
  output logic             sel_err
);
  logic [NFLAG-1:0] flags_q;
  logic [NFLAG-1:0] flags_d;
  logic [NFLAG-1:0] cmd_nxt;
  logic [NFLAG-1:0] alu_nxt;
  logic             cmd_ok;
  logic             flags_en;

  assign cmd_ok  = cmd_en && $onehot(cmd_sel);
  assign sel_err = cmd_en && !cmd_ok;

  for (genvar i = 0; i < NFLAG; i++) begin : g_bit
    assign cmd_nxt[i] = cmd_sel[i] ? cmd_set    : flags_q[i];
    assign alu_nxt[i] = alu_we[i]  ? alu_val[i] : flags_q[i];
  end

  always_comb begin
    flags_en = 1'b1;
    if (pop_load)    flags_d = pop_flags;
    else if (cmd_ok) flags_d = cmd_nxt;
    else begin
      flags_d  = alu_nxt;
      flags_en = |alu_we;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (flags_en) flags_q <= flags_d;
  end

  assign flags = flags_q;

  AST_POP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    pop_load |=> flags_q == $past(pop_flags)); // R2

  AST_ONE_FLAG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop_load && cmd_en && $onehot(cmd_sel)) |=>
      (((flags_q ^ $past(flags_q)) & ~$past(cmd_sel)) == '0) &&
      ((flags_q & $past(cmd_sel)) == ($past(cmd_set) ? $past(cmd_sel) : '0))); // R3

  AST_BAD_SEL_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop_load && cmd_en && !$onehot(cmd_sel) && alu_we == '0) |=> $stable(flags_q)); // R4

  AST_MASKED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop_load && !cmd_en) |=> ((flags_q ^ $past(flags_q)) & ~$past(alu_we)) == '0); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop_load && !cmd_en && alu_we == '0) |=> $stable(flags_q)); // R6
endmodule

// File: rtl/sbu_cond_eval.sv
module sbu_cond_eval
  import sbu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NFLAG-1:0]  flags,
  input  logic              br_req,
  input  logic              br_uncond,
  input  logic [CODE_W-1:0] br_cond,
  output logic              taken
);
  flag_idx_e sel_idx;
  logic      sel_flag;
  logic      cond_met;

  assign sel_idx  = flag_idx_e'(br_cond[CODE_W-1:1]);
  assign sel_flag = flags[sel_idx];
  assign cond_met = br_uncond || (sel_flag == br_cond[0]);
  assign taken    = br_req && cond_met;

  AST_NO_REQ_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    !br_req |-> !taken); // R9

  AST_UNCOND_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (br_req && br_uncond) |-> taken); // R8
endmodule

// File: rtl/status_branch_unit.sv
module status_branch_unit
  import sbu_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NFLAG-1:0]    alu_flags,
  input  logic [NFLAG-1:0]    alu_we,
  input  logic                bit_cmd_en,
  input  logic                bit_cmd_set,
  input  logic [NFLAG-1:0]    bit_sel,
  input  logic                pop_load,
  input  logic [NFLAG-1:0]    pop_flags,
  input  logic                br_req,
  input  logic                br_uncond,
  input  logic [CODE_W-1:0]   br_cond,
  input  logic [BYTE_W-1:0]   jr_hi,
  input  logic [BYTE_W-1:0]   jr_lo,
  output logic [NFLAG-1:0]    flags,
  output logic                taken,
  output logic [2*BYTE_W-1:0] jump_target,
  output logic [BYTE_W-1:0]   push_byte,
  output logic                sel_err
);
  localparam int unsigned PAD_W = BYTE_W - NFLAG;

  logic rst_n_sync;

  sbu_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  sbu_flag_store u_flags (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .pop_load  (pop_load),
    .pop_flags (pop_flags),
    .cmd_en    (bit_cmd_en),
    .cmd_set   (bit_cmd_set),
    .cmd_sel   (bit_sel),
    .alu_we    (alu_we),
    .alu_val   (alu_flags),
    .flags     (flags),
    .sel_err   (sel_err)
  );

  sbu_cond_eval u_cond (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .flags     (flags),
    .br_req    (br_req),
    .br_uncond (br_uncond),
    .br_cond   (br_cond),
    .taken     (taken)
  );

  assign jump_target = {jr_hi, jr_lo};
  assign push_byte   = {{PAD_W{1'b0}}, flags};

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n_sync |-> flags == '0); // R1
endmodule

// File: tb/sim_status_branch_unit.sv
`timescale 1ns/1ps
module sim_status_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  alu_flags, alu_we, bit_sel, pop_flags;
  logic        bit_cmd_en, bit_cmd_set, pop_load, br_req, br_uncond;
  logic [2:0]  br_cond;
  logic [7:0]  jr_hi, jr_lo;
  logic [3:0]  flags;
  logic        taken, sel_err;
  logic [15:0] jump_target;
  logic [7:0]  push_byte;

  int compared   = 0;
  int mismatched = 0;
  bit done       = 0;
  logic [3:0] mf;

  always #2.5 clk = ~clk;

  status_branch_unit u0 (
    .clk(clk), .rst_n(rst_n), .alu_flags(alu_flags), .alu_we(alu_we),
    .bit_cmd_en(bit_cmd_en), .bit_cmd_set(bit_cmd_set), .bit_sel(bit_sel),
    .pop_load(pop_load), .pop_flags(pop_flags), .br_req(br_req),
    .br_uncond(br_uncond), .br_cond(br_cond), .jr_hi(jr_hi), .jr_lo(jr_lo),
    .flags(flags), .taken(taken), .jump_target(jump_target),
    .push_byte(push_byte), .sel_err(sel_err)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic idle();
    alu_flags = 0; alu_we = 0; bit_cmd_en = 0; bit_cmd_set = 0; bit_sel = 0;
    pop_load = 0; pop_flags = 0; br_req = 0; br_uncond = 0; br_cond = 0;
    jr_hi = 0; jr_lo = 0;
  endtask

  function automatic int ones(input logic [3:0] v);
    int n = 0;
    for (int i = 0; i < 4; i++) if (v[i]) n++;
    return n;
  endfunction

  // One cycle: inputs already driven after a falling edge.
  task automatic step();
    bit   exp_taken, cmd_good;
    string ttag, ftag;
    int   idx;
    #1;
    if (!br_req) begin exp_taken = 0; ttag = "R9"; end
    else if (br_uncond) begin exp_taken = 1; ttag = "R8"; end
    else begin
      idx = int'(br_cond) / 2;
      exp_taken = (mf[idx] == br_cond[0]);
      ttag = "R7";
    end
    chk(ttag, "taken", taken, exp_taken);
    cmd_good = bit_cmd_en && (ones(bit_sel) == 1);
    chk("R4", "sel_err", sel_err, bit_cmd_en && !cmd_good);
    chk("R10", "jump_target", jump_target, {jr_hi, jr_lo});
    chk("R11", "push_byte", push_byte, {4'h0, mf});
    @(posedge clk);
    if (pop_load) begin mf = pop_flags; ftag = "R2"; end
    else if (cmd_good) begin
      for (int i = 0; i < 4; i++) if (bit_sel[i]) mf[i] = bit_cmd_set;
      ftag = "R3";
    end else begin
      for (int i = 0; i < 4; i++) if (alu_we[i]) mf[i] = alu_flags[i];
      ftag = (alu_we != 0) ? "R5" : (bit_cmd_en ? "R4" : "R6");
    end
    @(negedge clk);
    chk(ftag, "flags", flags, mf);
    idle();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    mf = 0;
    repeat (3) @(negedge clk);
    chk("R1", "flags in reset", flags, 4'h0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1", "flags after release", flags, 4'h0);

    // R3: set S, then branch on S set and on S clear
    bit_cmd_en = 1; bit_cmd_set = 1; bit_sel = 4'b1000; step();
    br_req = 1; br_cond = 3'b111; step();
    br_req = 1; br_cond = 3'b110; step();
    // R4: multi-bit select with ALU write still applied
    bit_cmd_en = 1; bit_cmd_set = 1; bit_sel = 4'b0110; alu_we = 4'b0001; alu_flags = 4'b1111; step();
    // R4: empty select alone
    bit_cmd_en = 1; bit_cmd_set = 1; bit_sel = 4'b0000; step();
    // R2: pop beats a valid command and an ALU write
    pop_load = 1; pop_flags = 4'b0110; bit_cmd_en = 1; bit_sel = 4'b0010; alu_we = 4'hF; step();
    // R3 beats ALU: clear Z while ALU tries to write everything
    bit_cmd_en = 1; bit_cmd_set = 0; bit_sel = 4'b0100; alu_we = 4'hF; alu_flags = 4'h0; step();
    // R5: masked ALU write
    alu_we = 4'b1010; alu_flags = 4'b1111; step();
    // R6 and R8
    br_req = 1; br_uncond = 1; br_cond = 3'b001; jr_hi = 8'hAB; jr_lo = 8'hCD; step();

    for (int n = 0; n < 3000; n++) begin
      alu_flags   = 4'($urandom);
      alu_we      = ($urandom % 3 == 0) ? 4'h0 : 4'($urandom);
      bit_cmd_en  = ($urandom % 4 == 0);
      bit_cmd_set = 1'($urandom);
      bit_sel     = ($urandom % 2 == 0) ? 4'(1 << ($urandom % 4)) : 4'($urandom);
      pop_load    = ($urandom % 8 == 0);
      pop_flags   = 4'($urandom);
      br_req      = 1'($urandom);
      br_uncond   = ($urandom % 5 == 0);
      br_cond     = 3'($urandom);
      jr_hi       = 8'($urandom);
      jr_lo       = 8'($urandom);
      step();
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule